// File: doc/BRIEF.md
# End-of-Conversion Interrupt Controller

This block turns per-slot conversion events into a small set of interrupt lines for a sampling converter with sixteen conversion slots. Each line watches one slot, chosen by software. The line takes that slot's event at one of two points: when the sample window closes, or when the conversion result is ready. A programmable cycle delay can push the event back. When the event lands, the line sets a sticky flag and emits a one-cycle interrupt pulse.

An event that lands while the flag is still set is recorded as an overflow. In normal mode, such an event produces no pulse. In continuous mode, the line pulses on every event whether or not its flag is set. Flags and overflows are cleared by writing ones to dedicated clear addresses. A per-slot retrigger map routes the pulses of line 0 or line 1 back as slot start requests. Software configures and observes everything through a simple write port and a separate combinational read port.

Top module: `eoc_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `irq` and `retrig` are low.
- R2: Each line is configured by one byte. Line l uses byte l%2 of the register at address 8+l/2. Within the byte, bits [5:0] select the source slot, bit 6 is the continuous bit and bit 7 is the enable bit. A source index of 16 or more never produces an event. A line whose enable bit is clear ignores events: its flag does not change and it produces no pulse.
- R3: An event that lands on a line whose flag is already set sets that line's bit in the overflow register at address 4.
- R4: With the continuous bit clear, an event that lands while the line's flag is set produces no pulse. With the continuous bit set, every event produces a pulse.
- R5: The flag register reads at address 2, one bit per line. Writing ones to address 3 clears the matching flags. If a clear and an event land on the same line in the same cycle, the flag stays set.
- R6: Writing ones to address 5 clears the matching overflow bits. The clear addresses always read zero.
- R7: Address 0 bit 0 selects the event point. 0 takes `acq_done`. 1 takes `conv_done`. Events on the other input are ignored.
- R8: Address 1 bits [15:0] hold a delay D. With D > 0, an event lands D cycles after it is seen. A new event seen while a delay is still counting restarts the count, so the two events land as one.
- R9: Address 6 holds a 2-bit code per slot s at bits [2s+1:2s]. Code 1 drives `retrig[s]` from `irq[0]`. Code 2 drives it from `irq[1]`. Codes 0 and 3 keep it low. The retrigger output appears in the same cycle as the pulse.
- R10: With D = 0, an event seen in one cycle gives a one-cycle `irq` pulse in the next cycle. No pulse appears without a landed event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_done | input | 16 | Per-slot end-of-sample-window pulses |
| conv_done | input | 16 | Per-slot end-of-conversion pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 4 | Interrupt pulses, one per line |
| retrig | output | 16 | Per-slot retrigger requests |

## Verification
The bench builds the block with its defaults: sixteen slots, four lines and a 16-bit delay. With four lines, both configuration registers are exercised, and a disabled line can share a source slot with an enabled one. With sixteen slots, the top slot index and indices past the last slot are both reachable. A delay of five cycles is short enough to restart a count partway through and still watch the merged event land.

// File: rtl/eoc_irq_pkg.sv
package eoc_irq_pkg;

  localparam int A_CFG     = 0;
  localparam int A_DLY     = 1;
  localparam int A_FLAG    = 2;
  localparam int A_FLAGCLR = 3;
  localparam int A_OVF     = 4;
  localparam int A_OVFCLR  = 5;
  localparam int A_RETRIG  = 6;
  localparam int A_SEL     = 8;

  typedef struct packed {
    logic       en;
    logic       cont;
    logic [5:0] src;
  } line_cfg_t;

  // picks one slot bit; indices beyond the populated slots read as zero
  function automatic logic slot_pick(input logic [5:0] src, input logic [63:0] vec);
    return vec[src];
  endfunction

  // delay countdown: reload on a fresh event, otherwise run down to zero
  function automatic logic [15:0] next_count(input logic [15:0] cnt,
                                             input logic [15:0] dly,
                                             input logic        ev);
    if (ev && dly != 16'd0) return dly;
    if (cnt != 16'd0)       return cnt - 16'd1;
    return 16'd0;
  endfunction

  function automatic logic retrig_hit(input logic [1:0] code, input logic i0, input logic i1);
    case (code)
      2'd1:    return i0;
      2'd2:    return i1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eoc_irq_regs.sv
module eoc_irq_regs
  import eoc_irq_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int NLINE  = 4,
  parameter int DLY_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NLINE-1:0]    flag,
  input  logic [NLINE-1:0]    ovf,
  output logic                pos_conv,
  output logic [DLY_W-1:0]    delay,
  output line_cfg_t           cfg [NLINE],
  output logic [2*NSLOT-1:0]  retrig_code,
  output logic [NLINE-1:0]    clr_flag,
  output logic [NLINE-1:0]    clr_ovf
);

  localparam int RT_W = 2 * NSLOT;

  assign clr_flag = (wr_en && wr_addr == ADDR_W'(A_FLAGCLR)) ? wr_data[NLINE-1:0] : '0;
  assign clr_ovf  = (wr_en && wr_addr == ADDR_W'(A_OVFCLR))  ? wr_data[NLINE-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_conv    <= 1'b0;
      delay       <= '0;
      retrig_code <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CFG))    pos_conv    <= wr_data[0];
      if (wr_addr == ADDR_W'(A_DLY))    delay       <= wr_data[DLY_W-1:0];
      if (wr_addr == ADDR_W'(A_RETRIG)) retrig_code <= wr_data[RT_W-1:0];
    end
  end

  for (genvar l = 0; l < NLINE; l++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg[l] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_SEL + l / 2))
        cfg[l] <= wr_data[8*(l%2) +: 8];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_CFG):    rd_data[0]          = pos_conv;
      ADDR_W'(A_DLY):    rd_data[DLY_W-1:0]  = delay;
      ADDR_W'(A_FLAG):   rd_data[NLINE-1:0]  = flag;
      ADDR_W'(A_OVF):    rd_data[NLINE-1:0]  = ovf;
      ADDR_W'(A_RETRIG): rd_data[RT_W-1:0]   = retrig_code;
      default: begin
        for (int l = 0; l < NLINE; l++)
          if (rd_addr == ADDR_W'(A_SEL + l / 2))
            rd_data[8*(l%2) +: 8] = cfg[l];
      end
    endcase
  end

endmodule

// File: rtl/eoc_irq_line.sv
module eoc_irq_line
  import eoc_irq_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_conv,
  input  line_cfg_t        cfg,
  input  logic [DLY_W-1:0] delay,
  input  logic [NSLOT-1:0] acq_done,
  input  logic [NSLOT-1:0] conv_done,
  input  logic             clr_flag,
  input  logic             clr_ovf,
  output logic             flag,
  output logic             ovf,
  output logic             irq
);

  logic [NSLOT-1:0] pick;
  logic             ev_seen;
  logic             deliver;
  logic [DLY_W-1:0] cnt;

  assign pick    = pos_conv ? conv_done : acq_done;
  assign ev_seen = cfg.en && slot_pick(cfg.src, 64'(pick));
  assign deliver = (ev_seen && delay == '0) || (cnt == DLY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
      ovf  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      cnt  <= DLY_W'(next_count(16'(cnt), 16'(delay), ev_seen));
      flag <= (flag & ~clr_flag) | deliver;
      ovf  <= (ovf & ~clr_ovf) | (deliver & flag);
      irq  <= deliver & (cfg.cont | ~flag);
    end
  end

  AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> flag); // R5
  AST_OVF_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && flag) |=> ovf); // R3
  AST_HELD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && flag && !cfg.cont) |=> !irq); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver |=> !irq); // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en && cnt == '0 && !clr_flag) |=> $stable(flag)); // R2

endmodule

// File: rtl/eoc_irq_ctrl.sv
module eoc_irq_ctrl
  import eoc_irq_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int NLINE  = 4,
  parameter int DLY_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  acq_done,
  input  logic [NSLOT-1:0]  conv_done,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NLINE-1:0]  irq,
  output logic [NSLOT-1:0]  retrig
);

  logic               pos_conv;
  logic [DLY_W-1:0]   delay;
  line_cfg_t          cfg [NLINE];
  logic [2*NSLOT-1:0] retrig_code;
  logic [NLINE-1:0]   clr_flag, clr_ovf, flag, ovf;

  eoc_irq_regs #(
    .NSLOT(NSLOT), .NLINE(NLINE), .DLY_W(DLY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flag(flag), .ovf(ovf),
    .pos_conv(pos_conv), .delay(delay), .cfg(cfg), .retrig_code(retrig_code),
    .clr_flag(clr_flag), .clr_ovf(clr_ovf)
  );

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    eoc_irq_line #(.NSLOT(NSLOT), .DLY_W(DLY_W)) u_line (
      .clk(clk), .rst_n(rst_n), .pos_conv(pos_conv), .cfg(cfg[l]), .delay(delay),
      .acq_done(acq_done), .conv_done(conv_done),
      .clr_flag(clr_flag[l]), .clr_ovf(clr_ovf[l]),
      .flag(flag[l]), .ovf(ovf[l]), .irq(irq[l])
    );
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_rt
    assign retrig[s] = retrig_hit(retrig_code[2*s +: 2], irq[0], irq[1]);
  end

  AST_RETRIG_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|retrig) |-> (irq[0] || irq[1])); // R9

endmodule

// File: tb/eoc_irq_ctrl_tb.sv
module eoc_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] acq_done = '0, conv_done = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq;
  logic [15:0] retrig;

  always #5 clk = ~clk;

  eoc_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .acq_done(acq_done), .conv_done(conv_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .retrig(retrig)
  );

  int    n_cmp = 0, n_bad = 0;
  string phase = "R1";
  bit    done = 0;

  // behavioural reference
  bit m_pos;
  int m_delay;
  bit m_en[4], m_cont[4], m_flag[4], m_ovf[4], m_irq[4];
  int m_src[4], m_cnt[4];
  bit [31:0] m_rt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_delay = 0; m_rt = 0;
      for (int l = 0; l < 4; l++) begin
        m_en[l] = 0; m_cont[l] = 0; m_src[l] = 0;
        m_flag[l] = 0; m_ovf[l] = 0; m_irq[l] = 0; m_cnt[l] = 0;
      end
    end else begin
      for (int l = 0; l < 4; l++) begin
        bit ev, land, clrf, clro;
        ev = m_en[l] && m_src[l] < 16 &&
             (m_pos ? conv_done[m_src[l]] : acq_done[m_src[l]]);
        land = (ev && m_delay == 0) || (m_cnt[l] == 1);
        clrf = wr_en && wr_addr == 4'd3 && wr_data[l];
        clro = wr_en && wr_addr == 4'd5 && wr_data[l];
        m_irq[l] = land && (m_cont[l] || !m_flag[l]);
        m_ovf[l] = (m_ovf[l] && !clro) || (land && m_flag[l]);
        m_flag[l] = (m_flag[l] && !clrf) || land;
        if (ev && m_delay != 0) m_cnt[l] = m_delay;
        else if (m_cnt[l] > 0) m_cnt[l] = m_cnt[l] - 1;
      end
      if (wr_en) begin
        case (wr_addr)
          4'd0: m_pos = wr_data[0];
          4'd1: m_delay = int'(wr_data[15:0]);
          4'd6: m_rt = wr_data;
          4'd8, 4'd9: begin
            for (int h = 0; h < 2; h++) begin
              int l;
              l = (wr_addr == 4'd9 ? 2 : 0) + h;
              m_src[l]  = int'(wr_data[8*h +: 6]);
              m_cont[l] = wr_data[8*h + 6];
              m_en[l]   = wr_data[8*h + 7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  function automatic bit [31:0] m_read(input bit [3:0] a);
    bit [31:0] r;
    r = 0;
    case (a)
      4'd0: r[0] = m_pos;
      4'd1: r = m_delay;
      4'd2: for (int l = 0; l < 4; l++) r[l] = m_flag[l];
      4'd4: for (int l = 0; l < 4; l++) r[l] = m_ovf[l];
      4'd6: r = m_rt;
      4'd8, 4'd9: for (int h = 0; h < 2; h++) begin
        int l;
        l = (a == 4'd9 ? 2 : 0) + h;
        r[8*h +: 8] = {m_en[l], m_cont[l], 6'(m_src[l])};
      end
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      bit [3:0]  ei;
      bit [15:0] er;
      for (int l = 0; l < 4; l++) ei[l] = m_irq[l];
      for (int s = 0; s < 16; s++)
        er[s] = (m_rt[2*s +: 2] == 2'd1) ? m_irq[0] :
                (m_rt[2*s +: 2] == 2'd2) ? m_irq[1] : 1'b0;
      check("irq", 32'(irq), 32'(ei));
      check("retrig", 32'(retrig), 32'(er));
      check($sformatf("rd_data@%0d", rd_addr), rd_data, m_read(rd_addr));
      rd_addr = (rd_addr == 4'd9) ? 4'd0 : rd_addr + 4'd1;
    end
  end

  task automatic step(input bit we, input bit [3:0] a, input bit [31:0] d,
                      input bit [15:0] acq, input bit [15:0] cv);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; acq_done = acq; conv_done = cv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    step(1, a, d, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: all registers and outputs zero after reset
    phase = "R1"; idle(12);
    // R2: source select, enable, out-of-range source
    phase = "R2";
    wr(4'd8, 32'h0000_8583);
    wr(4'd9, 32'h0000_CF03);
    step(0, 0, 0, 16'h0008, 0); idle(3);
    step(0, 0, 0, 16'h0020, 0); idle(3);
    step(0, 0, 0, 16'h8000, 0); idle(3);
    step(0, 0, 0, 16'h0400, 0); idle(3);
    wr(4'd9, 32'h0000_D0C3);
    step(0, 0, 0, 16'hFFFF, 0); idle(3);
    wr(4'd9, 32'h0000_CF03);
    // R4: held flag blocks pulse unless continuous
    phase = "R4";
    step(0, 0, 0, 16'h0008, 0); idle(2);
    step(0, 0, 0, 16'h8000, 0); step(0, 0, 0, 16'h8000, 0); idle(3);
    // R3: overflow bits observed through reads
    phase = "R3"; idle(10);
    // R5: clear flags, clear colliding with a new event
    phase = "R5";
    wr(4'd3, 32'hF); idle(10);
    step(1, 4'd3, 32'h1, 16'h0008, 0); idle(10);
    // R6: overflow clear
    phase = "R6";
    wr(4'd5, 32'hF); idle(10);
    // R7: event point selection
    phase = "R7";
    wr(4'd3, 32'hF); wr(4'd0, 32'h1);
    step(0, 0, 0, 16'h0020, 0); idle(2);
    step(0, 0, 0, 0, 16'h0020); idle(10);
    // R8: delay and restart
    phase = "R8";
    wr(4'd3, 32'hF); wr(4'd1, 32'd5);
    step(0, 0, 0, 0, 16'h0008); idle(7);
    step(0, 0, 0, 0, 16'h0008); idle(2);
    step(0, 0, 0, 0, 16'h0008); idle(10);
    wr(4'd1, 32'd0);
    // R9: retrigger routing
    phase = "R9";
    wr(4'd6, 32'h0000_0139); wr(4'd3, 32'hF);
    step(0, 0, 0, 0, 16'h0008); idle(2);
    step(0, 0, 0, 0, 16'h0020); idle(10);
    // R10: pulse timing, back-to-back in continuous mode
    phase = "R10";
    wr(4'd8, 32'h0000_85C3); wr(4'd3, 32'hF);
    step(0, 0, 0, 0, 16'h0008); step(0, 0, 0, 0, 16'h0008); step(0, 0, 0, 0, 16'h0008);
    idle(12);
    finish_run();
  end

endmodule